// File: doc/BRIEF.md
# One-Time-Programmable Array Slave Loader

This block sits inside a device that holds a write-once word array. While the device is in its loading mode, an outside programmer drives a shared bidirectional word port and three active-low strobes. The strobes are a command strobe, a data strobe and an address-step strobe. A falling command strobe latches an address together with a write/read selector. A falling data strobe either burns the port value into the selected word or turns the port around to return that word. A step strobe advances the address so that consecutive words need no new command phase.

Each stored bit can only move from 1 to 0. Writing therefore ANDs the new value into the stored word. A per-word pass flag reports whether the stored result equals the requested value. A cumulative pass flag stays high only while every write since reset has passed. Minimum spacings between strobes are measured in clock cycles, with one clock per oscillator period. A strobe that breaks a spacing rule is discarded and raises a sticky sequence-error flag.

Top module: `otp_slave_prog`

## Requirements
- R1: While reset is high and in the cycle after it, `all_ok` is 1 and `word_ok`, `seq_err` and `port_oe` are 0. Array contents survive reset, and the erased value is all ones.
- R2: A command-strobe fall within `T_SETTLE` cycles of reset release is discarded and sets `seq_err`. No address is loaded, so a later data strobe also does nothing.
- R3: On an accepted command-strobe fall, `port_in[0]` selects the operation: 1 means write and 0 means read-back. The word address is taken from `port_in[ADDR_W:1]`.
- R4: A write replaces the stored word with (stored AND `port_in`). `word_ok` drops to 0 when the data strobe is accepted. About `T_RECOVER` cycles after the data strobe rises, it shows 1 if the new stored word equals the written value and 0 otherwise.
- R5: A read-back drives the stored word on `port_out` with `port_oe` high within 3 cycles of the data-strobe fall, until the strobe rises. Whenever `port_oe` is low, `port_out` is 0.
- R6: `all_ok` clears on the first write whose check fails and stays 0 until reset. Passing writes and read-backs leave it unchanged.
- R7: A command or data strobe that falls within `T_RECOVER` cycles after a data-strobe rise is discarded and sets `seq_err`.
- R8: A data-strobe fall during the `T_ADDR_HOLD` window after a command-strobe fall, or while the command strobe is still low, is discarded and sets `seq_err`.
- R9: A step-strobe fall with an address loaded adds one to the word address. This applies when the block is idle or in recovery.
- R10: A step-strobe low pulse shorter than `T_INC_PULSE` cycles sets `seq_err`. The address step still takes effect.
- R11: A data-strobe fall within `T_INC_TO_PROG` cycles of an accepted step-strobe fall is discarded and sets `seq_err`.
- R12: `seq_err` stays 1 until reset once set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per oscillator period |
| rst | input | 1 | Synchronous active-high reset, marks entry into loading mode |
| addr_stb_n | input | 1 | Command strobe, falling edge latches address and operation |
| prog_stb_n | input | 1 | Data strobe, falling edge starts a write or read-back |
| step_n | input | 1 | Address-step strobe, active low |
| port_in | input | DATA_W | Port value driven by the programmer |
| port_out | output | DATA_W | Word returned during read-back, 0 otherwise |
| port_oe | output | 1 | High while the block drives the port |
| word_ok | output | 1 | Pass flag of the most recent write |
| all_ok | output | 1 | Cumulative pass flag since reset |
| seq_err | output | 1 | Sticky flag for discarded, mistimed strobes |

## Verification
The bench builds the block with a 16-word array and spacing windows of a few to a few dozen cycles: `T_SETTLE` 40, `T_ADDR_HOLD` 6, `T_RECOVER` 12, `T_INC_PULSE` 10, `T_INC_TO_PROG` 7. With windows this short, each rule can be broken a few cycles inside its limit and met a few cycles beyond it, and each error case runs after its own reset. The 16-word array lets the bench keep a full model of the array. It also lets the step strobe be exercised across ordinary neighbouring addresses, so every read-back can be checked against the ANDed history of that word.

// File: rtl/otp_slave_pkg.sv
package otp_slave_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_IDLE,
    ST_AHOLD,
    ST_FETCH,
    ST_PULSE,
    ST_RECOV
  } seq_state_t;

  localparam int OP_SEL_BIT = 0;

  localparam int PIN_ADDR = 0;
  localparam int PIN_PROG = 1;
  localparam int PIN_STEP = 2;
  localparam int NUM_PINS = 3;

endpackage

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] old_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[i] <= 1'b1;
        old_q[i] <= 1'b1;
      end else begin
        cur_q[i] <= pin_n[i];
        old_q[i] <= cur_q[i];
      end
    end
    assign fall[i] = old_q[i] & ~cur_q[i];
    assign rise[i] = ~old_q[i] & cur_q[i];
  end

endmodule

// File: rtl/otp_window.sv
module otp_window #(
  parameter int LIMIT      = 8,
  parameter bit START_BUSY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= START_BUSY ? CW'(LIMIT) : '0;
    end else if (start) begin
      cnt_q <= CW'(LIMIT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/otp_word_ram.sv
module otp_word_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end

endmodule

// File: rtl/otp_slave_prog.sv
module otp_slave_prog
  import otp_slave_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 16,
  parameter int T_SETTLE      = 1100,
  parameter int T_ADDR_HOLD   = 100,
  parameter int T_RECOVER     = 220,
  parameter int T_INC_PULSE   = 240,
  parameter int T_INC_TO_PROG = 170
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_stb_n,
  input  logic              prog_stb_n,
  input  logic              step_n,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe,
  output logic              word_ok,
  output logic              all_ok,
  output logic              seq_err
);

  localparam int WID_LIMIT = (T_INC_PULSE > 1) ? T_INC_PULSE - 1 : 1;

  logic [NUM_PINS-1:0] pins_n, fall, rise;
  logic [DATA_W-1:0]   port_q;
  seq_state_t          state_q;
  logic                have_addr_q, mode_prog_q, cmd_high_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q, res_q, rd_data, merged;
  logic                settle_busy, ahold_busy, recov_busy, gap_busy, wid_busy;
  logic                accept_addr, accept_prog, accept_step, recov_start;
  logic                violation, wr_en;

  assign pins_n[PIN_ADDR] = addr_stb_n;
  assign pins_n[PIN_PROG] = prog_stb_n;
  assign pins_n[PIN_STEP] = step_n;

  otp_strobe_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin_n(pins_n),
    .fall (fall),
    .rise (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) port_q <= '0;
    else     port_q <= port_in;
  end

  otp_window #(.LIMIT(T_SETTLE), .START_BUSY(1'b1)) u_settle (
    .clk(clk), .rst(rst), .start(1'b0), .busy(settle_busy)
  );
  otp_window #(.LIMIT(T_ADDR_HOLD)) u_ahold (
    .clk(clk), .rst(rst), .start(accept_addr), .busy(ahold_busy)
  );
  otp_window #(.LIMIT(T_RECOVER)) u_recov (
    .clk(clk), .rst(rst), .start(recov_start), .busy(recov_busy)
  );
  otp_window #(.LIMIT(T_INC_TO_PROG)) u_gap (
    .clk(clk), .rst(rst), .start(accept_step), .busy(gap_busy)
  );
  otp_window #(.LIMIT(WID_LIMIT)) u_wid (
    .clk(clk), .rst(rst), .start(accept_step), .busy(wid_busy)
  );

  assign merged = rd_data & data_q;
  assign wr_en  = (state_q == ST_FETCH) && mode_prog_q;

  otp_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rd_addr(addr_q),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_addr(addr_q),
    .wr_data(merged)
  );

  // Acceptance rules for each strobe edge; anything else is a violation.
  always_comb begin
    accept_addr = fall[PIN_ADDR] && (state_q == ST_IDLE);
    accept_prog = fall[PIN_PROG] && (state_q == ST_IDLE) && have_addr_q
                  && cmd_high_q && !gap_busy;
    accept_step = fall[PIN_STEP] && have_addr_q
                  && ((state_q == ST_IDLE) || (state_q == ST_RECOV));
    recov_start = rise[PIN_PROG]
                  && ((state_q == ST_FETCH) || (state_q == ST_PULSE));
    violation   = (fall[PIN_ADDR] && !accept_addr)
               || (fall[PIN_PROG] && !accept_prog)
               || (fall[PIN_STEP] && !accept_step)
               || (rise[PIN_STEP] && wid_busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SETTLE;
      have_addr_q <= 1'b0;
      mode_prog_q <= 1'b0;
      cmd_high_q  <= 1'b1;
      addr_q      <= '0;
      data_q      <= '0;
      res_q       <= '0;
      port_out    <= '0;
      port_oe     <= 1'b0;
      word_ok     <= 1'b0;
      all_ok      <= 1'b1;
      seq_err     <= 1'b0;
    end else begin
      seq_err <= seq_err | violation;

      if (fall[PIN_ADDR])      cmd_high_q <= 1'b0;
      else if (rise[PIN_ADDR]) cmd_high_q <= 1'b1;

      if (accept_step) addr_q <= addr_q + 1'b1;

      unique case (state_q)
        ST_SETTLE: begin
          if (!settle_busy) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept_addr) begin
            mode_prog_q <= port_q[OP_SEL_BIT];
            addr_q      <= port_q[ADDR_W:1];
            have_addr_q <= 1'b1;
            state_q     <= ST_AHOLD;
          end else if (accept_prog) begin
            data_q  <= port_q;
            word_ok <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_AHOLD: begin
          if (!ahold_busy) state_q <= ST_IDLE;
        end
        ST_FETCH: begin
          if (mode_prog_q) begin
            res_q <= merged;
          end else if (!rise[PIN_PROG]) begin
            port_out <= rd_data;
            port_oe  <= 1'b1;
          end
          state_q <= rise[PIN_PROG] ? ST_RECOV : ST_PULSE;
        end
        ST_PULSE: begin
          if (rise[PIN_PROG]) begin
            port_out <= '0;
            port_oe  <= 1'b0;
            state_q  <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          if (!recov_busy) begin
            if (mode_prog_q) begin
              word_ok <= (res_q == data_q);
              if (res_q != data_q) all_ok <= 1'b0;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_slave_prog_chk.sv
module otp_slave_prog_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] port_out,
  input logic              port_oe,
  input logic              word_ok,
  input logic              all_ok,
  input logic              seq_err,
  input logic              mode_prog
);

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (all_ok && !word_ok && !seq_err && !port_oe));

  a_r6_all_ok_stays_low: assert property (@(posedge clk) disable iff (rst)
    !all_ok |=> !all_ok);

  a_r6_clear_on_fail: assert property (@(posedge clk) disable iff (rst)
    $fell(all_ok) |-> !word_ok);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  a_r5_drive_only_readback: assert property (@(posedge clk) disable iff (rst)
    port_oe |-> !mode_prog);

  a_r5_quiet_port: assert property (@(posedge clk) disable iff (rst)
    !port_oe |-> (port_out == '0));

  a_r4_pass_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(word_ok) |-> mode_prog);

endmodule

bind otp_slave_prog otp_slave_prog_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_out (port_out),
  .port_oe  (port_oe),
  .word_ok  (word_ok),
  .all_ok   (all_ok),
  .seq_err  (seq_err),
  .mode_prog(mode_prog_q)
);

// File: tb/otp_slave_prog_test.sv
module otp_slave_prog_test;

  localparam int AW      = 4;
  localparam int DW      = 16;
  localparam int SETTLE  = 40;
  localparam int AHOLD   = 6;
  localparam int RECOV   = 12;
  localparam int INC_W   = 10;
  localparam int INC_GAP = 7;

  // {addr[4], write data[16], stored afterwards[16], word_ok, all_ok}
  localparam int VW = 38;
  localparam logic [VW-1:0] VEC [5] = '{
    {4'd1, 16'hA5A5, 16'hA5A5, 1'b1, 1'b1},
    {4'd2, 16'h0000, 16'h0000, 1'b1, 1'b1},
    {4'd1, 16'h2424, 16'h2424, 1'b1, 1'b1},
    {4'd2, 16'h00FF, 16'h0000, 1'b0, 1'b0},
    {4'd3, 16'h1234, 16'h1234, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_n = 1'b1, prog_n = 1'b1, step_n = 1'b1;
  logic [DW-1:0] port_in = '0;
  logic [DW-1:0] port_out;
  logic port_oe, word_ok, all_ok, seq_err;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  otp_slave_prog #(
    .ADDR_W(AW), .DATA_W(DW), .T_SETTLE(SETTLE), .T_ADDR_HOLD(AHOLD),
    .T_RECOVER(RECOV), .T_INC_PULSE(INC_W), .T_INC_TO_PROG(INC_GAP)
  ) uut (
    .clk(clk), .rst(rst), .addr_stb_n(addr_n), .prog_stb_n(prog_n),
    .step_n(step_n), .port_in(port_in), .port_out(port_out),
    .port_oe(port_oe), .word_ok(word_ok), .all_ok(all_ok), .seq_err(seq_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(SETTLE + 5);
  endtask

  task automatic cmd_phase(input logic wr, input logic [AW-1:0] a);
    port_in = {{(DW-AW-1){1'b0}}, a, wr};
    addr_n = 1'b0;
    tick(AHOLD + 4);
    addr_n = 1'b1;
    tick(3);
  endtask

  task automatic write_word(input logic [DW-1:0] d, input logic ok, input logic all, input string req);
    port_in = d;
    prog_n = 1'b0;
    tick(4);
    prog_n = 1'b1;
    tick(RECOV - 3);
    chk("R4 word_ok low before window", {31'd0, word_ok}, 32'd0);
    tick(7);
    chk(req, {31'd0, word_ok}, {31'd0, ok});
    chk("R6 all_ok", {31'd0, all_ok}, {31'd0, all});
  endtask

  task automatic read_word(input logic [DW-1:0] exp, input string req);
    port_in = '0;
    prog_n = 1'b0;
    tick(3);
    chk(req, {15'd0, port_oe, port_out}, {15'd0, 1'b1, exp});
    tick(2);
    prog_n = 1'b1;
    tick(3);
    chk("R5 port released", {15'd0, port_oe, port_out}, 32'd0);
    tick(RECOV + 3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    chk("R1 reset flags", {28'd0, all_ok, word_ok, seq_err, port_oe}, 32'h8);
    tick(SETTLE + 5);

    // R3 R4 R5 R6: table of writes, each followed by a read-back
    for (int i = 0; i < 5; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      cmd_phase(1'b1, v[37:34]);
      write_word(v[33:18], v[1], v[0], "R4 write verify");
      cmd_phase(1'b0, v[37:34]);
      read_word(v[17:2], "R3 R5 read-back of stored word");
    end
    chk("R12 no error on legal sequence", {31'd0, seq_err}, 32'd0);

    // R1 R6: reset restores the cumulative flag, the array is kept
    do_reset();
    chk("R6 all_ok restored by reset", {31'd0, all_ok}, 32'd1);
    cmd_phase(1'b0, 4'd3);
    read_word(16'h1234, "R1 array survives reset");

    // R9: step strobe advances the address
    cmd_phase(1'b1, 4'd8);
    write_word(16'hF0F0, 1'b1, 1'b1, "R9 write before step");
    step_n = 1'b0; tick(INC_W + 2); step_n = 1'b1; tick(3);
    write_word(16'h0F0F, 1'b1, 1'b1, "R9 write after step");
    cmd_phase(1'b0, 4'd9);
    read_word(16'h0F0F, "R9 stepped word");
    cmd_phase(1'b0, 4'd8);
    read_word(16'hF0F0, "R9 first word");
    chk("R10 full-width step no error", {31'd0, seq_err}, 32'd0);

    // R7: command strobe inside recovery is discarded
    cmd_phase(1'b0, 4'd3);
    prog_n = 1'b0; tick(4); prog_n = 1'b1; tick(4);
    cmd_phase(1'b1, 4'd1);
    chk("R7 early strobe flagged", {31'd0, seq_err}, 32'd1);
    tick(RECOV);
    read_word(16'h1234, "R7 old address and mode kept");

    // R8: data strobe inside the address hold window
    do_reset();
    port_in = {{(DW-AW-1){1'b0}}, 4'd5, 1'b1};
    addr_n = 1'b0; tick(3);
    port_in = '0; prog_n = 1'b0; tick(3); prog_n = 1'b1;
    tick(AHOLD + 2); addr_n = 1'b1; tick(RECOV + 4);
    chk("R8 hold violation flagged", {30'd0, seq_err, word_ok}, 32'd2);
    cmd_phase(1'b0, 4'd5);
    read_word(16'hFFFF, "R8 word untouched");

    // R10: short step pulse flags but still steps
    do_reset();
    cmd_phase(1'b0, 4'd1);
    step_n = 1'b0; tick(3); step_n = 1'b1; tick(3);
    chk("R10 short step flagged", {31'd0, seq_err}, 32'd1);
    tick(INC_GAP);
    read_word(16'h0000, "R10 address advanced to 2");

    // R11: data strobe too soon after step
    do_reset();
    cmd_phase(1'b1, 4'd10);
    step_n = 1'b0; tick(3);
    port_in = '0; prog_n = 1'b0; tick(3); prog_n = 1'b1;
    tick(INC_W); step_n = 1'b1; tick(RECOV + 4);
    chk("R11 early data strobe flagged", {30'd0, seq_err, word_ok}, 32'd2);
    cmd_phase(1'b0, 4'd11);
    read_word(16'hFFFF, "R11 stepped word untouched");

    // R2: command strobe before the settle time
    rst = 1'b1; tick(3); rst = 1'b0; tick(5);
    port_in = {{(DW-AW-1){1'b0}}, 4'd12, 1'b1};
    addr_n = 1'b0; tick(AHOLD + 4); addr_n = 1'b1;
    tick(SETTLE);
    chk("R2 early command flagged", {31'd0, seq_err}, 32'd1);
    port_in = '0; prog_n = 1'b0; tick(3);
    chk("R2 no operation without address", {31'd0, port_oe}, 32'd0);
    prog_n = 1'b1; tick(RECOV + 4);
    chk("R2 word_ok stays low", {31'd0, word_ok}, 32'd0);
    cmd_phase(1'b0, 4'd12);
    read_word(16'hFFFF, "R2 word 12 untouched");
    chk("R12 error still set", {31'd0, seq_err}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule